// File: doc/BRIEF.md
# Video-Mode Line and Frame Timing Sequencer

This block steps a display link through the regions of a video frame and, inside every line, through the regions of a line. Vertically a frame runs sync lines, back-porch lines, active lines and front-porch lines. Horizontally a line runs sync, back porch, active payload and then whatever blanking is left before the programmed line time ends. All horizontal durations are counted in link byte-clock cycles, which is the clock the block runs on, so no conversion from pixel timing happens here.

Each cycle the block reports a horizontal and a vertical region code, a line-start pulse, a frame-start pulse, a sync-start strobe and a flag saying whether the link may drop to low power. The low-power flag comes from a six-bit enable mask that has one bit per blanking region. All timing and mode inputs are plain register-style levels. They are captured once, in the cycle the run control is first seen high. While the run control is low, the block stays idle.

Three modes are supported. In the two sync-pulse modes (non-burst and burst) the line opens with a separate horizontal sync region. In the sync-event mode that region is folded into the back porch. When the programmed line time is shorter than sync, back porch and active payload together, the block flags a configuration error and sets the trailing blanking to zero cycles.

Top module: `vid_timing_seq`

## Requirements
- R1: After reset, and in every cycle in which the sequencer is not running, `active`, `line_start`, `frame_start`, `sync_start` and `lp_ok` are 0 and both region codes are 0. `cfg_err` is 0 after reset.
- R2: The configuration inputs are captured only in the cycle in which `run` is 1 and the sequencer is idle. Changes made while running have no effect until the next start.
- R3: In the cycle after `run` is first seen high, `active` is 1 and the first cycle of a new frame is presented. A low `run` makes the outputs idle one cycle later.
- R4: The horizontal region code is 0 for sync, 1 for back porch, 2 for active payload and 3 for trailing blanking. Each line shows these codes in that order, for `cfg_hsync_cyc`, `cfg_hback_cyc` and `cfg_hact_cyc` cycles, and the trailing blanking fills the line out to `cfg_line_cyc` cycles. A region of zero length is skipped.
- R5: If `cfg_line_cyc` is smaller than the sum of sync, back porch and active cycles, `cfg_err` is 1 from the start cycle on and the line lasts exactly that sum, with no trailing blanking. Otherwise `cfg_err` is 0.
- R6: The vertical region code is 0 for sync lines, 1 for back-porch lines, 2 for active lines and 3 for front-porch lines. A frame shows them in that order, with `cfg_vsync_ln`, `cfg_vback_ln`, `cfg_vact_ln` and `cfg_vfront_ln` lines, skips empty regions, and repeats for as long as `run` stays high.
- R7: Mode `2'b01` (sync events) never shows horizontal region 0, and its back porch lasts `cfg_hsync_cyc + cfg_hback_cyc` cycles. Modes `2'b00` and `2'b1x` (sync pulses, burst) keep sync as its own region.
- R8: `sync_start` is 1 in the first cycle of a line when the mode is sync events or `cfg_hsync_cyc` is nonzero, and is 0 in every other cycle.
- R9: `line_start` is 1 in the first cycle of every line. `frame_start` is 1 only in the first cycle of the first line of a frame.
- R10: `lp_ok` is 0 during horizontal sync and during active payload on active lines. Mask bit 0 applies to vertical sync lines, bit 1 to vertical back-porch lines and bit 3 to vertical front-porch lines, over the whole line outside horizontal sync. On active lines `lp_ok` is bit 2 AND bit 4 during the back porch, and bit 2 AND bit 5 during trailing blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Soft run control; 0 holds idle, rising starts a fresh frame |
| cfg_mode | input | 2 | 00 sync pulses, 01 sync events, 1x burst |
| cfg_hsync_cyc | input | HW | Horizontal sync width in byte cycles |
| cfg_hback_cyc | input | HW | Horizontal back porch in byte cycles |
| cfg_hact_cyc | input | HW | Active payload duration in byte cycles |
| cfg_line_cyc | input | LTW | Total line time in byte cycles |
| cfg_vsync_ln | input | VW | Vertical sync lines |
| cfg_vback_ln | input | VW | Vertical back-porch lines |
| cfg_vfront_ln | input | VW | Vertical front-porch lines |
| cfg_vact_ln | input | VAW | Active lines |
| cfg_lp_mask | input | 6 | Low-power enables per region |
| active | output | 1 | Sequencer is running |
| h_region | output | 2 | Horizontal region code |
| v_region | output | 2 | Vertical region code |
| line_start | output | 1 | First cycle of a line |
| frame_start | output | 1 | First cycle of a frame |
| sync_start | output | 1 | Sync-start strobe |
| lp_ok | output | 1 | Low power allowed this cycle |
| cfg_err | output | 1 | Captured line time too short |

## Verification
The hardest condition to reach from the ports is a configuration change while the sequencer is in the middle of a frame: the outputs must keep following the old timing. The stimulus rewrites mode, line time and mask partway through a run and keeps comparing against the old model. It then restarts and checks that the new values now take effect. A second difficult case is a line time shorter than its fixed regions, together with zero-length sync and empty vertical regions. One configuration combines all of these in burst mode, so skipping, clamping and the error flag are exercised in the same frames.

// File: rtl/vts_pkg.sv
// Shared region codes, mode code and low-power mask bit positions for the
// video timing sequencer. Assumes the codes are decoded by downstream logic.
package vts_pkg;
    typedef enum logic [1:0] {
        RG_SYNC  = 2'd0,
        RG_BACK  = 2'd1,
        RG_ACT   = 2'd2,
        RG_FRONT = 2'd3
    } region_e;

    localparam logic [1:0] MODE_EVENTS = 2'b01;

    localparam int LPB_VSYNC = 0;
    localparam int LPB_VBACK = 1;
    localparam int LPB_VACT  = 2;
    localparam int LPB_VFRNT = 3;
    localparam int LPB_HBACK = 4;
    localparam int LPB_HFRNT = 5;
endpackage

// File: rtl/vts_cfg.sv
// Configuration capture: turns the raw timing inputs into region boundaries
// and wrap limits, and registers them on load. Assumes LTW >= HW + 2.
module vts_cfg #(
    parameter  int HW  = 16,
    parameter  int LTW = 32,
    parameter  int VW  = 10,
    parameter  int VAW = 16,
    localparam int HBW = HW + 2,
    localparam int VBW = ((VW > VAW) ? VW : VAW) + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [1:0]     mode,
    input  logic [HW-1:0]  hsa,
    input  logic [HW-1:0]  hbp,
    input  logic [HW-1:0]  hact,
    input  logic [LTW-1:0] hline,
    input  logic [VW-1:0]  vsa,
    input  logic [VW-1:0]  vbp,
    input  logic [VW-1:0]  vfp,
    input  logic [VAW-1:0] vact,
    input  logic [5:0]     lp_mask,
    output logic           ev_q,
    output logic           sync_en_q,
    output logic           err_q,
    output logic [HBW-1:0] hb1_q,
    output logic [HBW-1:0] hb2_q,
    output logic [HBW-1:0] hb3_q,
    output logic [LTW-1:0] hlast_q,
    output logic [VBW-1:0] vb1_q,
    output logic [VBW-1:0] vb2_q,
    output logic [VBW-1:0] vb3_q,
    output logic [VBW-1:0] vlast_q,
    output logic [5:0]     lp_q
);
    import vts_pkg::*;

    logic           ev;
    logic [HBW-1:0] hb1, hb2, hb3;
    logic [LTW-1:0] sum_ext, hlen, hlast;
    logic           over;
    logic [VBW-1:0] vb1, vb2, vb3, vsum, vlast;

    // Derive boundaries and wrap limits from the raw inputs.
    always_comb begin
        ev      = (mode == MODE_EVENTS);
        hb1     = ev ? '0 : HBW'(hsa);
        hb2     = HBW'(hsa) + HBW'(hbp);
        hb3     = hb2 + HBW'(hact);
        sum_ext = LTW'(hb3);
        over    = sum_ext > hline;
        hlen    = over ? sum_ext : hline;
        hlast   = (hlen == '0) ? '0 : hlen - 1'b1;
        vb1     = VBW'(vsa);
        vb2     = vb1 + VBW'(vbp);
        vb3     = vb2 + VBW'(vact);
        vsum    = vb3 + VBW'(vfp);
        vlast   = (vsum == '0) ? '0 : vsum - 1'b1;
    end

    // Hold the derived configuration from one start to the next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q <= 1'b0; sync_en_q <= 1'b0; err_q <= 1'b0;
            hb1_q <= '0; hb2_q <= '0; hb3_q <= '0; hlast_q <= '0;
            vb1_q <= '0; vb2_q <= '0; vb3_q <= '0; vlast_q <= '0;
            lp_q <= '0;
        end else if (load) begin
            ev_q      <= ev;
            sync_en_q <= ev || (hsa != '0);
            err_q     <= over;
            hb1_q     <= hb1;
            hb2_q     <= hb2;
            hb3_q     <= hb3;
            hlast_q   <= hlast;
            vb1_q     <= vb1;
            vb2_q     <= vb2;
            vb3_q     <= vb3;
            vlast_q   <= vlast;
            lp_q      <= lp_mask;
        end
    end
endmodule

// File: rtl/vts_wrapcnt.sv
// Wrapping position counter: counts 0..last while enabled, held at 0 by clr.
// Assumes last is stable while counting.
module vts_wrapcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] last,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    assign wrap = en && (cnt == last);

    // Advance the position, returning to zero after the last value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt <= '0;
        else if (wrap)      cnt <= '0;
        else if (en)        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/vts_region.sv
// Region decoder: maps a position to one of four ordered regions using three
// ascending boundaries. Assumes b1 <= b2 <= b3.
module vts_region #(
    parameter int W = 16
) (
    input  logic [W-1:0]     cnt,
    input  logic [W-1:0]     b1,
    input  logic [W-1:0]     b2,
    input  logic [W-1:0]     b3,
    output vts_pkg::region_e code
);
    import vts_pkg::*;

    // Pick the first region whose end lies beyond the position.
    always_comb begin
        if      (cnt < b1) code = RG_SYNC;
        else if (cnt < b2) code = RG_BACK;
        else if (cnt < b3) code = RG_ACT;
        else               code = RG_FRONT;
    end
endmodule

// File: rtl/vts_lp.sv
// Low-power permission: combines the current regions with the captured
// per-region enable mask. Assumes the mask bit layout of vts_pkg.
module vts_lp (
    input  logic             run_q,
    input  vts_pkg::region_e hreg,
    input  vts_pkg::region_e vreg,
    input  logic [5:0]       mask,
    output logic             ok
);
    import vts_pkg::*;

    // Select the enable bit(s) that govern the current cycle.
    always_comb begin
        ok = 1'b0;
        if (run_q && hreg != RG_SYNC) begin
            unique case (vreg)
                RG_SYNC:  ok = mask[LPB_VSYNC];
                RG_BACK:  ok = mask[LPB_VBACK];
                RG_FRONT: ok = mask[LPB_VFRNT];
                RG_ACT: begin
                    if (hreg == RG_BACK)       ok = mask[LPB_VACT] & mask[LPB_HBACK];
                    else if (hreg == RG_FRONT) ok = mask[LPB_VACT] & mask[LPB_HFRNT];
                    else                       ok = 1'b0;
                end
                default:  ok = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/vid_timing_seq.sv
// Video-mode line/frame sequencer top: captures configuration when run is
// first seen high, then walks horizontal positions in byte-clock cycles and
// vertical positions in lines, reporting regions, strobes and low-power
// permission. Assumes the clock is the link byte clock.
module vid_timing_seq #(
    parameter  int HW  = 16,
    parameter  int LTW = 32,
    parameter  int VW  = 10,
    parameter  int VAW = 16,
    localparam int HBW = HW + 2,
    localparam int VBW = ((VW > VAW) ? VW : VAW) + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [1:0]     cfg_mode,
    input  logic [HW-1:0]  cfg_hsync_cyc,
    input  logic [HW-1:0]  cfg_hback_cyc,
    input  logic [HW-1:0]  cfg_hact_cyc,
    input  logic [LTW-1:0] cfg_line_cyc,
    input  logic [VW-1:0]  cfg_vsync_ln,
    input  logic [VW-1:0]  cfg_vback_ln,
    input  logic [VW-1:0]  cfg_vfront_ln,
    input  logic [VAW-1:0] cfg_vact_ln,
    input  logic [5:0]     cfg_lp_mask,
    output logic           active,
    output logic [1:0]     h_region,
    output logic [1:0]     v_region,
    output logic           line_start,
    output logic           frame_start,
    output logic           sync_start,
    output logic           lp_ok,
    output logic           cfg_err
);
    import vts_pkg::*;

    logic           running, start;
    logic           ev_q, sync_en_q;
    logic [HBW-1:0] hb1_q, hb2_q, hb3_q;
    logic [LTW-1:0] hlast_q, hcnt;
    logic [VBW-1:0] vb1_q, vb2_q, vb3_q, vlast_q, vcnt;
    logic [5:0]     lp_q;
    logic           hwrap, vwrap;
    region_e        hcode, vcode;
    logic           lp_raw;

    // Track the run control; a start is run high while still idle.
    always_ff @(posedge clk) begin
        if (!rst_n) running <= 1'b0;
        else        running <= run;
    end
    assign start = run && !running;

    vts_cfg #(.HW(HW), .LTW(LTW), .VW(VW), .VAW(VAW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(start), .mode(cfg_mode),
        .hsa(cfg_hsync_cyc), .hbp(cfg_hback_cyc), .hact(cfg_hact_cyc),
        .hline(cfg_line_cyc), .vsa(cfg_vsync_ln), .vbp(cfg_vback_ln),
        .vfp(cfg_vfront_ln), .vact(cfg_vact_ln), .lp_mask(cfg_lp_mask),
        .ev_q(ev_q), .sync_en_q(sync_en_q), .err_q(cfg_err),
        .hb1_q(hb1_q), .hb2_q(hb2_q), .hb3_q(hb3_q), .hlast_q(hlast_q),
        .vb1_q(vb1_q), .vb2_q(vb2_q), .vb3_q(vb3_q), .vlast_q(vlast_q),
        .lp_q(lp_q)
    );

    vts_wrapcnt #(.W(LTW)) u_hcnt (
        .clk(clk), .rst_n(rst_n), .clr(!running), .en(running),
        .last(hlast_q), .cnt(hcnt), .wrap(hwrap)
    );

    vts_wrapcnt #(.W(VBW)) u_vcnt (
        .clk(clk), .rst_n(rst_n), .clr(!running), .en(hwrap),
        .last(vlast_q), .cnt(vcnt), .wrap(vwrap)
    );

    vts_region #(.W(LTW)) u_hreg (
        .cnt(hcnt), .b1(LTW'(hb1_q)), .b2(LTW'(hb2_q)), .b3(LTW'(hb3_q)),
        .code(hcode)
    );

    vts_region #(.W(VBW)) u_vreg (
        .cnt(vcnt), .b1(vb1_q), .b2(vb2_q), .b3(vb3_q), .code(vcode)
    );

    vts_lp u_lp (
        .run_q(running), .hreg(hcode), .vreg(vcode), .mask(lp_q), .ok(lp_raw)
    );

    // Gate every output with the running state.
    always_comb begin
        active      = running;
        h_region    = running ? hcode : 2'd0;
        v_region    = running ? vcode : 2'd0;
        line_start  = running && (hcnt == '0);
        frame_start = line_start && (vcnt == '0);
        sync_start  = line_start && sync_en_q;
        lp_ok       = lp_raw;
    end
endmodule

// File: rtl/vts_chk.sv
// Property checker for the timing sequencer, attached by bind below.
module vts_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       active,
    input logic [1:0] h_region,
    input logic       line_start,
    input logic       frame_start,
    input logic       sync_start,
    input logic       lp_ok,
    input logic       ev_mode,
    input logic       vwrap
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!line_start && !frame_start && !sync_start && !lp_ok)); // R1
    AST_START_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> frame_start); // R3
    AST_H_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && !line_start) |-> (h_region >= $past(h_region))); // R4
    AST_FRAME_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        vwrap |=> (frame_start || !active)); // R6
    AST_EVENTS_NO_HSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ev_mode) |-> (h_region != 2'd0)); // R7
    AST_SYNC_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_start |-> line_start); // R8
    AST_FRAME_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> line_start); // R9
    AST_HSYNC_NO_LP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && h_region == 2'd0) |-> !lp_ok); // R10
endmodule

bind vid_timing_seq vts_chk u_chk (
    .clk(clk), .rst_n(rst_n), .active(active), .h_region(h_region),
    .line_start(line_start), .frame_start(frame_start),
    .sync_start(sync_start), .lp_ok(lp_ok), .ev_mode(ev_q), .vwrap(vwrap)
);

// File: tb/tb_vid_timing_seq.sv
`timescale 1ns/1ps
module tb_vid_timing_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic [15:0] cfg_hsync_cyc = '0, cfg_hback_cyc = '0, cfg_hact_cyc = '0;
    logic [31:0] cfg_line_cyc = '0;
    logic [9:0]  cfg_vsync_ln = '0, cfg_vback_ln = '0, cfg_vfront_ln = '0;
    logic [15:0] cfg_vact_ln = '0;
    logic [5:0]  cfg_lp_mask = '0;
    logic        active, line_start, frame_start, sync_start, lp_ok, cfg_err;
    logic [1:0]  h_region, v_region;

    int checks = 0;
    int errors = 0;
    bit reported = 0;

    typedef struct packed {
        logic       act;
        logic [1:0] h;
        logic [1:0] v;
        logic       ls;
        logic       fs;
        logic       ss;
        logic       lp;
    } exp_t;
    exp_t q[$];

    // Model copy of the configuration captured at start.
    int m_mode, m_hsa, m_hbp, m_hact, m_line, m_vsa, m_vbp, m_vact, m_vfp;
    logic [5:0] m_mask;

    vid_timing_seq dut (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_mode(cfg_mode),
        .cfg_hsync_cyc(cfg_hsync_cyc), .cfg_hback_cyc(cfg_hback_cyc),
        .cfg_hact_cyc(cfg_hact_cyc), .cfg_line_cyc(cfg_line_cyc),
        .cfg_vsync_ln(cfg_vsync_ln), .cfg_vback_ln(cfg_vback_ln),
        .cfg_vfront_ln(cfg_vfront_ln), .cfg_vact_ln(cfg_vact_ln),
        .cfg_lp_mask(cfg_lp_mask), .active(active), .h_region(h_region),
        .v_region(v_region), .line_start(line_start), .frame_start(frame_start),
        .sync_start(sync_start), .lp_ok(lp_ok), .cfg_err(cfg_err)
    );

    always #2.5 clk = ~clk;

    task automatic check_eq(string req, string what, int act_v, int exp_v);
        checks++;
        if (act_v != exp_v) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act_v, exp_v, $time);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
    endtask

    // Expected outputs for cycle k of a run, derived from R3..R10.
    function automatic exp_t model(int k);
        exp_t e;
        bit ev;
        int b1, b2, b3, hl, vl, hc, ln, v1, v2, v3;
        ev = (m_mode == 1);
        b1 = ev ? 0 : m_hsa;
        b2 = m_hsa + m_hbp;
        b3 = b2 + m_hact;
        hl = (m_line > b3) ? m_line : b3;
        if (hl == 0) hl = 1;
        v1 = m_vsa; v2 = v1 + m_vbp; v3 = v2 + m_vact;
        vl = v3 + m_vfp;
        if (vl == 0) vl = 1;
        hc = k % hl;
        ln = (k / hl) % vl;
        e.act = 1'b1;
        e.h = (hc < b1) ? 2'd0 : (hc < b2) ? 2'd1 : (hc < b3) ? 2'd2 : 2'd3;
        e.v = (ln < v1) ? 2'd0 : (ln < v2) ? 2'd1 : (ln < v3) ? 2'd2 : 2'd3;
        e.ls = (hc == 0);
        e.fs = e.ls && (ln == 0);
        e.ss = e.ls && (ev || m_hsa != 0);
        if (e.h == 2'd0) e.lp = 1'b0;
        else if (e.v == 2'd0) e.lp = m_mask[0];
        else if (e.v == 2'd1) e.lp = m_mask[1];
        else if (e.v == 2'd3) e.lp = m_mask[3];
        else if (e.h == 2'd1) e.lp = m_mask[2] & m_mask[4];
        else if (e.h == 2'd3) e.lp = m_mask[2] & m_mask[5];
        else e.lp = 1'b0;
        return e;
    endfunction

    // Monitor: compare each queued expectation with the outputs mid-cycle.
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                check_eq(e.act ? "R3" : "R1", "active", active, e.act);
                check_eq(e.act ? "R4" : "R1", "h_region", h_region, e.h);
                check_eq(e.act ? "R6" : "R1", "v_region", v_region, e.v);
                check_eq(e.act ? "R9" : "R1", "line_start", line_start, e.ls);
                check_eq(e.act ? "R9" : "R1", "frame_start", frame_start, e.fs);
                check_eq(e.act ? "R8" : "R1", "sync_start", sync_start, e.ss);
                check_eq(e.act ? "R10" : "R1", "lp_ok", lp_ok, e.lp);
            end
        end
    end

    task automatic set_cfg(int mode, int hsa, int hbp, int hact, int line,
                           int vsa, int vbp, int vact, int vfp, logic [5:0] mask);
        cfg_mode = mode[1:0];
        cfg_hsync_cyc = hsa[15:0]; cfg_hback_cyc = hbp[15:0];
        cfg_hact_cyc = hact[15:0]; cfg_line_cyc = line;
        cfg_vsync_ln = vsa[9:0]; cfg_vback_ln = vbp[9:0];
        cfg_vact_ln = vact[15:0]; cfg_vfront_ln = vfp[9:0];
        cfg_lp_mask = mask;
    endtask

    // Driver: start a run, push n expected cycles, optionally rewrite the
    // configuration mid-run (R2), then stop and expect an idle cycle.
    task automatic run_seq(int n, int chg_at);
        exp_t idle;
        int sum;
        @(negedge clk);
        m_mode = cfg_mode; m_hsa = cfg_hsync_cyc; m_hbp = cfg_hback_cyc;
        m_hact = cfg_hact_cyc; m_line = cfg_line_cyc; m_vsa = cfg_vsync_ln;
        m_vbp = cfg_vback_ln; m_vact = cfg_vact_ln; m_vfp = cfg_vfront_ln;
        m_mask = cfg_lp_mask;
        run = 1'b1;
        for (int k = 0; k < n; k++) q.push_back(model(k));
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (k == 1) begin
                sum = m_hsa + m_hbp + m_hact;
                check_eq("R5", "cfg_err", cfg_err, (m_line < sum) ? 1 : 0);
            end
            if (k == chg_at) set_cfg(1, 1, 0, 1, 3, 0, 0, 1, 0, 6'b000000); // R2
        end
        run = 1'b0;
        idle = '0;
        q.push_back(idle);
        @(negedge clk);
        @(negedge clk);
        check_eq("R3", "queue drained", q.size(), 0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_eq("R1", "active", active, 0);
        check_eq("R1", "line_start", line_start, 0);
        check_eq("R1", "lp_ok", lp_ok, 0);
        check_eq("R1", "cfg_err", cfg_err, 0);
        check_eq("R1", "h_region", h_region, 0);

        // R4 R6 R10: sync-pulse mode, all low-power bits set
        set_cfg(0, 2, 3, 4, 12, 1, 1, 2, 1, 6'b111111);
        run_seq(130, -1);
        // R7 R8: sync-event mode, empty vertical back porch
        set_cfg(1, 3, 1, 5, 14, 2, 0, 3, 1, 6'b101010);
        run_seq(170, -1);
        // R5 R8: burst, zero sync width, line too short, empty regions
        set_cfg(2, 0, 2, 6, 5, 0, 1, 2, 0, 6'b010101);
        run_seq(60, -1);
        // R2: rewrite inputs mid-run; old timing must continue
        set_cfg(0, 1, 1, 2, 8, 1, 1, 1, 1, 6'b110110);
        run_seq(70, 20);
        // R2: the rewritten configuration applies after restart
        run_seq(40, -1);
        // R10: active-line mask combinations with bit 2 cleared
        set_cfg(3, 1, 2, 2, 9, 1, 0, 2, 1, 6'b111011);
        run_seq(60, -1);

        report();
        $finish;
    end
endmodule